// File: doc/BRIEF.md
# Multi-port bulk frame demultiplexer

The block takes a single byte stream, as delivered by a shared bulk-out pipe, and fans it out to four serial transmit channels. The stream is cut into fixed frames of 512 bytes, with a start-of-frame flag on the first byte. Each frame holds four sub-blocks of 128 bytes, and sub-block `c` always belongs to channel `c`. Every sub-block opens with a four-byte header: the channel index, a write token, a payload length and a reserved byte. The payload follows the header.

For each sub-block the header is checked. If it is valid, exactly the declared number of payload bytes goes to the addressed channel's transmit FIFO over a valid/ready byte port. The bytes that follow are padding and are swallowed. A header that fails its check makes the whole sub-block silent and bumps a saturating error counter. While a payload byte waits on a busy channel, the input stalls. Forwarding is a zero-latency pass-through, so a byte reaches its channel in the same cycle it is presented.

Top module: `frame_demux`

## Requirements
- R1: A byte accepted with `in_sof_i` high is byte 0 of a frame. A frame is NUM_CH sub-blocks of SUB_BYTES bytes, and sub-block c (frame bytes c*SUB_BYTES to c*SUB_BYTES+SUB_BYTES-1) belongs to channel c. Bytes after the last byte of a frame, up to the next start flag, are accepted and dropped, and they do not touch the error counter.
- R2: Header byte offsets inside a sub-block are: offset 0 is the channel index, offset 1 is the token (must be 0x02), offset 2 is the payload length L, and offset 3 is reserved. The value of offset 3 has no effect on routing or on the counter.
- R3: For a valid header with 1 <= L <= 124, sub-block bytes at offsets 4 to 3+L appear in order on channel c's data port. Each appears with its valid bit high in the same cycle the byte is on the input.
- R4: A valid header with L = 0 forwards nothing and does not change the error counter.
- R5: Bytes at offsets 4+L to 127 are consumed and never forwarded.
- R6: A sub-block whose token byte is not 0x02 forwards nothing, and the error counter rises by one.
- R7: A sub-block whose length byte is above 124 forwards nothing, and the error counter rises by one.
- R8: A sub-block whose index byte is not equal to its position c in the frame forwards nothing, and the error counter rises by one.
- R9: `in_ready_o` is low only while a valid input byte is a forwarded payload byte whose channel has its ready low. No byte is lost or repeated under back-pressure.
- R10: At most one channel valid is high at any time, and a channel valid is never high without `in_valid_i`.
- R11: The error counter is zero after reset, rises by at most one per cycle, and holds at its all-ones value once reached.
- R12: A start flag in the middle of a frame restarts the frame at byte 0. The interrupted sub-block forwards nothing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Input stream byte |
| in_sof_i | input | 1 | Marks the byte as frame byte 0 |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted this cycle when high with valid |
| ch_data_o | output | 8*NUM_CH | Per-channel byte, channel c in bits 8c+7:8c |
| ch_valid_o | output | NUM_CH | Per-channel byte valid |
| ch_ready_i | input | NUM_CH | Per-channel FIFO ready |
| err_count_o | output | CNT_W | Saturating count of rejected headers |

## Verification
The checker assumes that the stream source holds a byte and its start flag steady until the byte is accepted. It also assumes that channel ready inputs settle before the clock edge and do not depend on the channel valid outputs. The bench drives every input just after a rising edge, so each byte stays on the bus until `in_ready_o` is seen high. The channel ready lines come from a free-running pseudo-random register in the bench that never looks at the channel valids. Under that stimulus, the stall and single-target properties can be checked against the ports every cycle.

// File: rtl/fdmx_pkg.sv
`timescale 1ns/1ps
package fdmx_pkg;
  typedef logic [7:0] byte_t;

  // header layout inside a sub-block; the reserved byte sits at offset 3
  localparam int unsigned HDR_BYTES = 4;
  localparam int unsigned OFS_IDX   = 0;
  localparam int unsigned OFS_TOK   = 1;
  localparam int unsigned OFS_LEN   = 2;
  localparam int unsigned OFS_LAST  = 3;

  typedef struct packed {
    byte_t idx;
    byte_t tok;
    byte_t len;
  } hdr_t;
endpackage

// File: rtl/fdmx_pos_track.sv
`timescale 1ns/1ps
module fdmx_pos_track #(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned SUB_BYTES = 128,
  localparam int unsigned OFF_W    = $clog2(SUB_BYTES),
  localparam int unsigned SUB_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             sof_i,
  output logic [OFF_W-1:0] off_o,
  output logic [SUB_W-1:0] sub_o,
  output logic             live_o
);
  logic [OFF_W-1:0] off_q;
  logic [SUB_W-1:0] sub_q;
  logic             live_q;

  // position of the byte on the bus now; a start flag forces byte 0
  assign off_o  = sof_i ? '0 : off_q;
  assign sub_o  = sof_i ? '0 : sub_q;
  assign live_o = sof_i | live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= '0;
      sub_q  <= '0;
      live_q <= 1'b0;
    end else if (take_i && live_o) begin
      if (off_o == OFF_W'(SUB_BYTES - 1)) begin
        off_q <= '0;
        if (sub_o == SUB_W'(NUM_CH - 1)) begin
          sub_q  <= '0;
          live_q <= 1'b0;
        end else begin
          sub_q  <= sub_o + 1'b1;
          live_q <= 1'b1;
        end
      end else begin
        off_q  <= off_o + 1'b1;
        sub_q  <= sub_o;
        live_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fdmx_hdr_check.sv
`timescale 1ns/1ps
module fdmx_hdr_check
  import fdmx_pkg::*;
#(
  parameter int unsigned OFF_W   = 7,
  parameter int unsigned SUB_W   = 2,
  parameter int unsigned MAX_LEN = 124,
  parameter logic [7:0]  TOKEN   = 8'h02
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             live_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [SUB_W-1:0] sub_i,
  input  byte_t            byte_i,
  output logic             open_o,
  output byte_t            len_o,
  output logic             bad_o
);
  hdr_t hdr_q;
  logic open_q;
  logic hdr_ok;
  logic step;

  assign step   = take_i & live_i;
  assign hdr_ok = (hdr_q.idx == byte_t'(sub_i)) &&
                  (hdr_q.tok == TOKEN) &&
                  (hdr_q.len <= byte_t'(MAX_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q  <= '0;
      open_q <= 1'b0;
    end else if (step) begin
      if (off_i == OFF_W'(OFS_IDX)) begin
        hdr_q.idx <= byte_i;
        open_q    <= 1'b0;
      end
      if (off_i == OFF_W'(OFS_TOK)) hdr_q.tok <= byte_i;
      if (off_i == OFF_W'(OFS_LEN)) hdr_q.len <= byte_i;
      // verdict once the whole header is in; reserved byte is not looked at
      if (off_i == OFF_W'(OFS_LAST)) open_q <= hdr_ok && (hdr_q.len != '0);
    end
  end

  assign open_o = open_q;
  assign len_o  = hdr_q.len;
  assign bad_o  = step && (off_i == OFF_W'(OFS_LAST)) && !hdr_ok;
endmodule

// File: rtl/fdmx_err_cnt.sv
`timescale 1ns/1ps
module fdmx_err_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '0;
    else if (inc_i && ~&cnt_o)    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/frame_demux.sv
`timescale 1ns/1ps
module frame_demux
  import fdmx_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned SUB_BYTES = 128,
  parameter logic [7:0]  TOKEN     = 8'h02,
  parameter int unsigned CNT_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [7:0]           in_data_i,
  input  logic                 in_sof_i,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  output logic [NUM_CH*8-1:0]  ch_data_o,
  output logic [NUM_CH-1:0]    ch_valid_o,
  input  logic [NUM_CH-1:0]    ch_ready_i,
  output logic [CNT_W-1:0]     err_count_o
);
  localparam int unsigned OFF_W   = $clog2(SUB_BYTES);
  localparam int unsigned SUB_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned MAX_LEN = SUB_BYTES - HDR_BYTES;

  logic             sof_hit;
  logic             take;
  logic [OFF_W-1:0] cur_off;
  logic [SUB_W-1:0] cur_sub;
  logic             cur_live;
  logic             hdr_open;
  byte_t            hdr_len;
  logic             hdr_bad;
  byte_t            off_b;
  byte_t            pay_idx;
  logic             fwd_slot;

  assign sof_hit = in_valid_i & in_sof_i;
  assign take    = in_valid_i & in_ready_o;

  fdmx_pos_track #(
    .NUM_CH    (NUM_CH),
    .SUB_BYTES (SUB_BYTES)
  ) u_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .sof_i  (sof_hit),
    .off_o  (cur_off),
    .sub_o  (cur_sub),
    .live_o (cur_live)
  );

  fdmx_hdr_check #(
    .OFF_W   (OFF_W),
    .SUB_W   (SUB_W),
    .MAX_LEN (MAX_LEN),
    .TOKEN   (TOKEN)
  ) u_hdr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .live_i (cur_live),
    .off_i  (cur_off),
    .sub_i  (cur_sub),
    .byte_i (in_data_i),
    .open_o (hdr_open),
    .len_o  (hdr_len),
    .bad_o  (hdr_bad)
  );

  fdmx_err_cnt #(
    .CNT_W (CNT_W)
  ) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (hdr_bad),
    .cnt_o  (err_count_o)
  );

  // payload window: past the header and inside the declared length
  assign off_b    = byte_t'(cur_off);
  assign pay_idx  = off_b - byte_t'(HDR_BYTES);
  assign fwd_slot = cur_live && hdr_open &&
                    (off_b >= byte_t'(HDR_BYTES)) && (pay_idx < hdr_len);

  assign in_ready_o = fwd_slot ? ch_ready_i[cur_sub] : 1'b1;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_valid_o[c]       = in_valid_i & fwd_slot & (cur_sub == SUB_W'(c));
    assign ch_data_o[c*8 +: 8] = in_data_i;
  end
endmodule

// File: rtl/fdmx_chk.sv
`timescale 1ns/1ps
module fdmx_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [NUM_CH-1:0] ch_valid_o,
  input logic [NUM_CH-1:0] ch_ready_i,
  input logic [CNT_W-1:0]  err_count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_one_target_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_valid_o));

  assert_valid_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_valid_o) |-> in_valid_i);

  assert_stall_on_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ch_valid_o & ~ch_ready_i)) |-> !in_ready_o);

  assert_no_spurious_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_ready_o) |-> (|(ch_valid_o & ~ch_ready_i)));

  assert_err_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (err_count_o == $past(err_count_o)) ||
             (err_count_o == $past(err_count_o) + 1'b1));

  assert_err_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_count_o == CNT_MAX) |=> (err_count_o == CNT_MAX));
endmodule

bind frame_demux fdmx_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .ch_valid_o  (ch_valid_o),
  .ch_ready_i  (ch_ready_i),
  .err_count_o (err_count_o)
);

// File: tb/frame_demux_test.sv
`timescale 1ns/1ps
module frame_demux_test;
  localparam int NUM_CH = 4;
  localparam int SUB    = 128;
  localparam int CNT_W  = 8;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [7:0]          in_data = '0;
  logic                in_sof = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [NUM_CH*8-1:0] ch_data;
  logic [NUM_CH-1:0]   ch_valid;
  logic [NUM_CH-1:0]   ch_ready = '1;
  logic [CNT_W-1:0]    err_cnt;

  frame_demux #(.NUM_CH(NUM_CH), .SUB_BYTES(SUB), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .in_data_i(in_data), .in_sof_i(in_sof),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .ch_data_o(ch_data),
    .ch_valid_o(ch_valid), .ch_ready_i(ch_ready), .err_count_o(err_cnt));

  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int exp_err = 0;
  bit done = 1'b0;
  bit bp_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] exp_q [NUM_CH][$];
  logic [7:0] h_idx [NUM_CH];
  logic [7:0] h_tok [NUM_CH];
  logic [7:0] h_len [NUM_CH];
  logic [7:0] h_rsv [NUM_CH];
  int pseed = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // channel ready pattern, independent of the design outputs
  initial forever begin
    @(posedge clk);
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ch_ready = bp_on ? (lfsr[3:0] | lfsr[7:4]) : '1;
  end

  // monitor: every accepted channel byte is compared against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (ch_valid[c] && ch_ready[c]) begin
          if (exp_q[c].size() == 0) begin
            check(1'b0, "R5 unexpected byte", int'(ch_data[c*8 +: 8]), -1);
          end else begin
            logic [7:0] e;
            e = exp_q[c].pop_front();
            check(ch_data[c*8 +: 8] == e, "R3 payload byte", int'(ch_data[c*8 +: 8]), int'(e));
          end
        end
      end
      if (in_valid && !in_ready)
        check(|(ch_valid & ~ch_ready), "R9 stall cause", int'(ch_valid), int'(~ch_ready));
    end
  end

  task automatic send_byte(input logic [7:0] b, input bit sof);
    in_data  = b;
    in_sof   = sof;
    in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  task automatic set_hdr(input int c, input int idx, input int tok, input int len, input int rsv);
    h_idx[c] = 8'(idx);
    h_tok[c] = 8'(tok);
    h_len[c] = 8'(len);
    h_rsv[c] = 8'(rsv);
  endtask

  task automatic good_hdrs(input int l0, input int l1, input int l2, input int l3);
    set_hdr(0, 0, 2, l0, 0);
    set_hdr(1, 1, 2, l1, 0);
    set_hdr(2, 2, 2, l2, 0);
    set_hdr(3, 3, 2, l3, 0);
  endtask

  // driver: builds a frame from the header arrays, pushes expectations
  task automatic send_frame(input int nbytes);
    for (int p = 0; p < nbytes; p++) begin
      int c;
      int off;
      bit ok;
      logic [7:0] b;
      c   = p / SUB;
      off = p % SUB;
      ok  = (h_idx[c] == 8'(c)) && (h_tok[c] == 8'h02) && (h_len[c] <= 8'd124);
      case (off)
        0: b = h_idx[c];
        1: b = h_tok[c];
        2: b = h_len[c];
        3: b = h_rsv[c];
        default: b = 8'(pseed + c * 37 + off * 5);
      endcase
      if (off == 3 && !ok && exp_err < CMAX) exp_err++;
      if (off >= 4 && ok && (off - 4) < int'(h_len[c])) exp_q[c].push_back(b);
      send_byte(b, p == 0);
    end
    pseed += 11;
  endtask

  task automatic settle_and_check(input string tag);
    @(negedge clk);
    check(int'(err_cnt) == exp_err, {tag, " error count"}, int'(err_cnt), exp_err);
    for (int c = 0; c < NUM_CH; c++)
      check(exp_q[c].size() == 0, {tag, " all expected bytes forwarded"}, exp_q[c].size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R9 reset ready", int'(in_ready), 1);
    check(ch_valid == '0, "R10 reset valid", int'(ch_valid), 0);
    check(err_cnt == '0, "R11 reset count", int'(err_cnt), 0);

    // R3 R4 R5: full, minimal, mid and zero lengths
    good_hdrs(124, 1, 60, 0);
    send_frame(NUM_CH * SUB);
    settle_and_check("R3 R4 R5 frame");

    // R9: same traffic under random back-pressure
    bp_on = 1'b1;
    good_hdrs(30, 124, 0, 77);
    send_frame(NUM_CH * SUB);
    good_hdrs(5, 6, 7, 124);
    send_frame(NUM_CH * SUB);
    settle_and_check("R9 backpressure");

    // R6 R7 R8: one bad header of each kind
    set_hdr(0, 0, 2, 10, 0);
    set_hdr(1, 1, 3, 10, 0);
    set_hdr(2, 2, 2, 125, 0);
    set_hdr(3, 0, 2, 10, 0);
    send_frame(NUM_CH * SUB);
    settle_and_check("R6 R7 R8 bad headers");
    bp_on = 1'b0;

    // R2: reserved byte value is ignored
    set_hdr(0, 0, 2, 5, 8'hAA);
    set_hdr(1, 1, 2, 124, 8'hFF);
    set_hdr(2, 2, 2, 0, 8'h55);
    set_hdr(3, 3, 2, 3, 8'h01);
    send_frame(NUM_CH * SUB);
    settle_and_check("R2 reserved byte");

    // R1: bytes after a frame and before the next start flag are dropped
    for (int k = 0; k < 40; k++) send_byte(8'((k % 4 == 1) ? 2 : (k % 4 == 2) ? 9 : 0), 1'b0);
    settle_and_check("R1 out of frame bytes");

    // R12: restart in the middle of sub-block 1
    good_hdrs(124, 50, 20, 20);
    send_frame(150);
    good_hdrs(12, 13, 14, 15);
    send_frame(NUM_CH * SUB);
    settle_and_check("R12 restart");

    // R11: saturation of the error counter
    for (int f = 0; f < 70; f++) begin
      set_hdr(0, 0, 7, 4, 0);
      set_hdr(1, 1, 0, 4, 0);
      set_hdr(2, 2, 2, 200, 0);
      set_hdr(3, 2, 2, 4, 0);
      send_frame(NUM_CH * SUB);
    end
    settle_and_check("R11 saturation");
    check(int'(err_cnt) == CMAX, "R11 held at max", int'(err_cnt), CMAX);

    // traffic still flows after saturation
    good_hdrs(9, 0, 124, 2);
    send_frame(NUM_CH * SUB);
    settle_and_check("R3 after saturation");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule